// File: doc/BRIEF.md
# Page Program and Erase Engine

This block is the write back end of a serial flash model. A command front-end has already decoded the opcode and the address. It hands over one of four operations: page program, sector erase, block erase or chip erase. For a program, it then streams data bytes into the engine. The engine collects them in a page-sized buffer that records which byte positions were written.

The operation is committed only when the front-end reports the chip-select rise. That rise must fall on a byte boundary, and the protection logic must accept the operation. When committed, the engine sweeps the affected region through a one-byte-per-cycle write port into an on-chip byte array. Busy stays high for a fixed, parameterised number of cycles. Done then pulses for one cycle.

Programming combines each new byte with the stored byte by bitwise AND, so it can only clear bits. Erasing writes all ones. During a chip erase, the front-end can flag individual bytes as protected, and those bytes are skipped.

Top module: `flash_pe_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_we_o` are low.
- R2: Page program (`cmd_op_i` = 0) stores each supplied byte at consecutive positions from the start offset `cmd_addr_i[7:0]` within page `cmd_addr_i[ARRAY_AW-1:8]`. Busy rises in the cycle after an accepted chip-select rise and stays high for exactly max(PROG_CYC, 256) cycles. `done_o` is high for exactly one cycle, the first cycle after busy falls.
- R3: When the data passes offset 255, the position wraps to offset 0 of the same page. Bytes outside that page are never written.
- R4: When more than 256 bytes are supplied, a later byte replaces the earlier byte buffered at the same wrapped position.
- R5: Bytes of the page that received no data keep their previous contents.
- R6: A chip-select rise with `cs_aligned_i` low discards the pending operation. It writes nothing and busy stays low. A later aligned rise without a new command starts nothing.
- R7: A programmed byte becomes the bitwise AND of the new data and the previous contents.
- R8: Sector erase (`cmd_op_i` = 1) writes 0xFF to every byte of the aligned 2^SECT_W-byte region containing `cmd_addr_i`, and leaves all other bytes unchanged. Busy lasts max(ERASE_CYC, 2^ARRAY_AW) cycles.
- R9: Block erase (`cmd_op_i` = 2) writes 0xFF to every byte of the aligned 2^BLK_W-byte region containing `cmd_addr_i`, and leaves all other bytes unchanged.
- R10: Chip erase (`cmd_op_i` = 3) writes 0xFF to every array byte, except a byte whose write address is presented while `wr_prot_i` is high; such a byte is left unchanged.
- R11: A chip-select rise with `prot_ok_i` low starts nothing and changes no byte.
- R12: While busy, command, data byte and chip-select inputs have no effect. They neither alter the running operation nor queue a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle pulse: a new operation with the op and address below |
| cmd_op_i | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmd_addr_i | input | ARRAY_AW | Start address of the operation |
| byte_valid_i | input | 1 | Data byte strobe for program |
| byte_data_i | input | 8 | Data byte |
| cs_rise_i | input | 1 | One-cycle pulse: chip-select has risen |
| cs_aligned_i | input | 1 | The chip-select rise came right after a complete byte |
| prot_ok_i | input | 1 | Protection logic accepts the pending operation |
| wr_prot_i | input | 1 | Byte at `mem_addr_o` is protected (chip erase only) |
| rd_addr_i | input | ARRAY_AW | Array read address |
| rd_data_o | output | 8 | Array read data, combinational |
| busy_o | output | 1 | Self-timed operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ARRAY_AW | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
A wrong valid bit or write pointer in the page buffer shows up as one misplaced or missing byte. That error is visible on the read port as soon as done pulses. A mis-decoded region base or length shows up as erased bytes outside the intended region, or as stale bytes inside it. Timer faults show up at the ports within one operation, as a busy window that is too long or too short, or as a done pulse that is missing or too wide. A pending flag that is not cleared shows up as busy rising on a later, command-less chip-select rise.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } pe_op_e;
endpackage

// File: rtl/pe_page_buf.sv
module pe_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [PAGE_W-1:0] start_off_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o
);
  localparam int PB = 1 << PAGE_W;

  logic [7:0]        data_q [PB];
  logic [PB-1:0]     vld_q;
  logic [PAGE_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
      ptr_q <= start_off_i;
    end else if (wr_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + 1'b1;  // wraps inside the page
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) data_q[ptr_q] <= wr_data_i;
  end

  assign rd_data_o  = data_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];
endmodule

// File: rtl/pe_byte_array.sv
module pe_byte_array #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [7:0]    rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [7:0]    rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pe_seq.sv
module pe_seq
  import pe_pkg::*;
#(
  parameter int AW      = 11,
  parameter int PAGE_W  = 8,
  parameter int SECT_W  = 12,
  parameter int BLK_W   = 15,
  parameter int PROG_T  = 256,
  parameter int ERASE_T = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  pe_op_e            cmd_op_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic              cs_rise_i,
  input  logic              cs_aligned_i,
  input  logic              prot_ok_i,
  input  logic              wr_prot_i,
  input  logic              buf_valid_i,
  input  logic [7:0]        buf_data_i,
  input  logic [7:0]        old_data_i,
  output logic              accept_bytes_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int TMAX   = (PROG_T > ERASE_T) ? PROG_T : ERASE_T;
  localparam int CW     = $clog2(TMAX + 1);
  localparam int SECT_E = (SECT_W < AW) ? SECT_W : AW;
  localparam int BLK_E  = (BLK_W < AW) ? BLK_W : AW;

  localparam logic [CW-1:0] PROG_LIM  = CW'(PROG_T - 1);
  localparam logic [CW-1:0] ERASE_LIM = CW'(ERASE_T - 1);
  localparam logic [CW-1:0] LEN_PAGE  = CW'(1 << PAGE_W);
  localparam logic [CW-1:0] LEN_SECT  = CW'(1 << SECT_E);
  localparam logic [CW-1:0] LEN_BLK   = CW'(1 << BLK_E);
  localparam logic [CW-1:0] LEN_CHIP  = CW'(1 << AW);
  localparam logic [AW-1:0] M_PAGE    = ~AW'((1 << PAGE_W) - 1);
  localparam logic [AW-1:0] M_SECT    = ~AW'((1 << SECT_E) - 1);
  localparam logic [AW-1:0] M_BLK     = ~AW'((1 << BLK_E) - 1);

  logic          busy_q, done_q, pend_q;
  pe_op_e        op_q, run_op_q;
  logic [AW-1:0] addr_q, base_q;
  logic [CW-1:0] len_q, lim_q, cnt_q;

  logic [AW-1:0] mask_sel;
  logic [CW-1:0] len_sel, lim_sel;
  logic          start, in_range;

  // region geometry of the pending op
  always_comb begin
    unique case (op_q)
      OP_PROG: begin mask_sel = M_PAGE; len_sel = LEN_PAGE; lim_sel = PROG_LIM;  end
      OP_SECT: begin mask_sel = M_SECT; len_sel = LEN_SECT; lim_sel = ERASE_LIM; end
      OP_BLK:  begin mask_sel = M_BLK;  len_sel = LEN_BLK;  lim_sel = ERASE_LIM; end
      default: begin mask_sel = '0;     len_sel = LEN_CHIP; lim_sel = ERASE_LIM; end
    endcase
  end

  assign start = pend_q && cs_rise_i && cs_aligned_i && prot_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      op_q     <= OP_PROG;
      run_op_q <= OP_PROG;
      addr_q   <= '0;
      base_q   <= '0;
      len_q    <= '0;
      lim_q    <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == lim_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        if (cs_rise_i) begin
          pend_q <= 1'b0;  // any deselect ends the pending command
          if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= '0;
            run_op_q <= op_q;
            base_q   <= addr_q & mask_sel;
            len_q    <= len_sel;
            lim_q    <= lim_sel;
          end
        end
        if (cmd_valid_i) begin
          pend_q <= 1'b1;
          op_q   <= cmd_op_i;
          addr_q <= cmd_addr_i;
        end
      end
    end
  end

  // the busy timer also indexes the sweep
  assign in_range   = busy_q && (cnt_q < len_q);
  assign mem_addr_o = base_q | cnt_q[AW-1:0];
  assign buf_idx_o  = cnt_q[PAGE_W-1:0];

  always_comb begin
    unique case (run_op_q)
      OP_PROG: begin
        mem_we_o    = in_range && buf_valid_i;
        mem_wdata_o = buf_data_i & old_data_i;
      end
      OP_CHIP: begin
        mem_we_o    = in_range && !wr_prot_i;
        mem_wdata_o = 8'hFF;
      end
      default: begin
        mem_we_o    = in_range;
        mem_wdata_o = 8'hFF;
      end
    endcase
  end

  assign accept_bytes_o = pend_q && !busy_q && (op_q == OP_PROG);
  assign busy_o         = busy_q;
  assign done_o         = done_q;
endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
  import pe_pkg::*;
#(
  parameter int ARRAY_AW  = 11,
  parameter int PAGE_W    = 8,
  parameter int SECT_W    = 12,
  parameter int BLK_W     = 15,
  parameter int PROG_CYC  = 1000,
  parameter int ERASE_CYC = 20000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [ARRAY_AW-1:0] cmd_addr_i,
  input  logic                byte_valid_i,
  input  logic [7:0]          byte_data_i,
  input  logic                cs_rise_i,
  input  logic                cs_aligned_i,
  input  logic                prot_ok_i,
  input  logic                wr_prot_i,
  input  logic [ARRAY_AW-1:0] rd_addr_i,
  output logic [7:0]          rd_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                mem_we_o,
  output logic [ARRAY_AW-1:0] mem_addr_o,
  output logic [7:0]          mem_wdata_o
);
  localparam int PAGE_BYTES  = 1 << PAGE_W;
  localparam int ARRAY_BYTES = 1 << ARRAY_AW;
  localparam int PROG_T      = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
  localparam int ERASE_T     = (ERASE_CYC > ARRAY_BYTES) ? ERASE_CYC : ARRAY_BYTES;

  logic              accept_bytes, buf_clr, buf_wr, buf_valid;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data, old_data;

  assign buf_clr = cmd_valid_i && !busy_o;
  assign buf_wr  = byte_valid_i && accept_bytes && !cmd_valid_i;

  pe_page_buf #(.PAGE_W(PAGE_W)) i_page_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (buf_clr),
    .start_off_i (cmd_addr_i[PAGE_W-1:0]),
    .wr_i        (buf_wr),
    .wr_data_i   (byte_data_i),
    .rd_idx_i    (buf_idx),
    .rd_data_o   (buf_data),
    .rd_valid_o  (buf_valid)
  );

  pe_seq #(
    .AW      (ARRAY_AW),
    .PAGE_W  (PAGE_W),
    .SECT_W  (SECT_W),
    .BLK_W   (BLK_W),
    .PROG_T  (PROG_T),
    .ERASE_T (ERASE_T)
  ) i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_valid_i    (cmd_valid_i),
    .cmd_op_i       (pe_op_e'(cmd_op_i)),
    .cmd_addr_i     (cmd_addr_i),
    .cs_rise_i      (cs_rise_i),
    .cs_aligned_i   (cs_aligned_i),
    .prot_ok_i      (prot_ok_i),
    .wr_prot_i      (wr_prot_i),
    .buf_valid_i    (buf_valid),
    .buf_data_i     (buf_data),
    .old_data_i     (old_data),
    .accept_bytes_o (accept_bytes),
    .buf_idx_o      (buf_idx),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o)
  );

  pe_byte_array #(.AW(ARRAY_AW)) i_array (
    .clk_i     (clk_i),
    .we_i      (mem_we_o),
    .waddr_i   (mem_addr_o),
    .wdata_i   (mem_wdata_o),
    .raddr_a_i (mem_addr_o),
    .rdata_a_o (old_data),
    .raddr_b_i (rd_addr_i),
    .rdata_b_o (rd_data_o)
  );
endmodule

// File: rtl/flash_pe_engine_chk.sv
module flash_pe_engine_chk #(
  parameter int AW     = 11,
  parameter int PAGE_W = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic [AW-1:0] cmd_addr_i,
  input logic          cs_rise_i,
  input logic          cs_aligned_i,
  input logic          prot_ok_i,
  input logic          wr_prot_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [7:0]    mem_wdata_o
);
  logic [1:0]         op_q;
  logic [AW-PAGE_W-1:0] pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0;
      pg_q <= '0;
    end else if (cmd_valid_i && !busy_o) begin
      op_q <= cmd_op_i;
      pg_q <= cmd_addr_i[AW-1:PAGE_W];
    end
  end

  a_r2_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  a_r2_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_q == 2'd0) |-> (mem_addr_o[AW-1:PAGE_W] == pg_q));

  a_r6_misaligned_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cs_rise_i && !cs_aligned_i) |=> !busy_o);

  a_r8_erase_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && op_q != 2'd0) |-> (mem_wdata_o == 8'hFF));

  a_r10_chip_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == 2'd3 && wr_prot_i) |-> !mem_we_o);

  a_r11_reject_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cs_rise_i && !prot_ok_i) |=> !busy_o);
endmodule

bind flash_pe_engine flash_pe_engine_chk #(.AW(ARRAY_AW), .PAGE_W(PAGE_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_op_i     (cmd_op_i),
  .cmd_addr_i   (cmd_addr_i),
  .cs_rise_i    (cs_rise_i),
  .cs_aligned_i (cs_aligned_i),
  .prot_ok_i    (prot_ok_i),
  .wr_prot_i    (wr_prot_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o)
);

// File: tb/test_flash_pe_engine.sv
module test_flash_pe_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 11;
  localparam int DEPTH      = 1 << AW;
  localparam int SECT_W     = 9;
  localparam int BLK_W      = 10;
  localparam int PROG_CYC   = 300;
  localparam int ERASE_CYC  = 64;
  localparam int T_PROG     = (PROG_CYC > 256) ? PROG_CYC : 256;
  localparam int T_ERASE    = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          cs_rise = 1'b0;
  logic          cs_aligned = 1'b0;
  logic          prot_ok = 1'b0;
  logic          wr_prot;
  logic          prot_lo_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wr_prot = prot_lo_en && (mem_addr < AW'(256));

  flash_pe_engine #(
    .ARRAY_AW (AW), .PAGE_W (8), .SECT_W (SECT_W), .BLK_W (BLK_W),
    .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC)
  ) i_flash_pe_engine (
    .clk_i (clk), .rst_ni (rst_n),
    .cmd_valid_i (cmd_valid), .cmd_op_i (cmd_op), .cmd_addr_i (cmd_addr),
    .byte_valid_i (byte_valid), .byte_data_i (byte_data),
    .cs_rise_i (cs_rise), .cs_aligned_i (cs_aligned), .prot_ok_i (prot_ok),
    .wr_prot_i (wr_prot), .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .busy_o (busy), .done_o (done), .mem_we_o (mem_we),
    .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    int first = -1;
    int act = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      if (rd_data !== model[a]) begin
        if (first < 0) begin first = a; act = int'(rd_data); end
        bad++;
      end
    end
    if (first < 0) chk(1'b1, req, "array", 0, 0);
    else chk(1'b0, req, $sformatf("array @%0h (%0d bad)", first, bad), act, int'(model[first]));
  endtask

  task automatic send_cmd(input logic [1:0] op, input int addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_bytes(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      byte_valid = 1'b1; byte_data = 8'(base + k * 7);
      @(negedge clk);
    end
    byte_valid = 1'b0;
  endtask

  task automatic cs_end(input bit aligned, input bit ok);
    cs_rise = 1'b1; cs_aligned = aligned; prot_ok = ok;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0; prot_ok = 1'b0;
  endtask

  task automatic wait_op(input int exp_t, input string req);
    int n = 0;
    while (busy === 1'b1 && n < 100000) begin n++; @(negedge clk); end
    chk(n == exp_t, req, "busy cycles", n, exp_t);
    chk(done === 1'b1, req, "done pulse", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, req, "done width", int'(done), 0);
  endtask

  task automatic model_prog(input int addr, input int n, input int base);
    logic [7:0] pb [256];
    bit         pv [256];
    int pg = addr & ~255;
    for (int i = 0; i < 256; i++) pv[i] = 1'b0;
    for (int k = 0; k < n; k++) begin
      pb[(addr + k) & 255] = 8'(base + k * 7);
      pv[(addr + k) & 255] = 1'b1;
    end
    for (int i = 0; i < 256; i++) if (pv[i]) model[pg + i] = model[pg + i] & pb[i];
  endtask

  task automatic model_erase(input int lo, input int len);
    for (int a = lo; a < lo + len; a++) model[a] = 8'hFF;
  endtask

  task automatic do_prog(input int addr, input int n, input int base, input string req);
    send_cmd(2'd0, addr);
    send_bytes(n, base);
    cs_end(1'b1, 1'b1);
    model_prog(addr, n, base);
    wait_op(T_PROG, req);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    chk(mem_we === 1'b0, "R1", "we after reset", int'(mem_we), 0);
  endtask

  task automatic t_chip_init;
    send_cmd(2'd3, 0);
    cs_end(1'b1, 1'b1);
    model_erase(0, DEPTH);
    wait_op(T_ERASE, "R10");
    compare_all("R10");
  endtask

  task automatic t_prog_basic;  // R2 R5
    do_prog(12'h110, 5, 8'h31, "R2");
    compare_all("R2_R5");
  endtask

  task automatic t_prog_wrap;  // R3
    do_prog(12'h2FE, 4, 8'hA0, "R3");
    compare_all("R3");
  endtask

  task automatic t_prog_overflow;  // R4
    do_prog(12'h300, 260, 8'h05, "R4");
    compare_all("R4");
  endtask

  task automatic t_prog_and;  // R7
    rd_addr = AW'(12'h111); #1;
    do_prog(12'h111, 1, 8'h0F, "R7");
    rd_addr = AW'(12'h111); #1;
    chk(rd_data === model[12'h111], "R7", "AND result", int'(rd_data), int'(model[12'h111]));
  endtask

  task automatic t_misaligned;  // R6
    send_cmd(2'd0, 12'h120);
    send_bytes(3, 8'h00);
    cs_end(1'b0, 1'b1);
    chk(busy === 1'b0, "R6", "busy after misaligned rise", int'(busy), 0);
    cs_end(1'b1, 1'b1);
    chk(busy === 1'b0, "R6", "busy after stale rise", int'(busy), 0);
    repeat (5) @(negedge clk);
    compare_all("R6");
  endtask

  task automatic t_reject;  // R11
    send_cmd(2'd1, 12'h100);
    cs_end(1'b1, 1'b0);
    chk(busy === 1'b0, "R11", "busy after reject", int'(busy), 0);
    repeat (5) @(negedge clk);
    compare_all("R11");
  endtask

  task automatic t_busy_ignore;  // R12
    int n = 0;
    send_cmd(2'd0, 12'h180);
    send_bytes(2, 8'h40);
    cs_end(1'b1, 1'b1);
    model_prog(12'h180, 2, 8'h40);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = AW'(12'h100);
    @(negedge clk);
    cmd_valid = 1'b0;
    send_bytes(3, 8'h11);
    cs_end(1'b1, 1'b1);
    while (busy === 1'b1 && n < 100000) begin n++; @(negedge clk); end
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R12", "no queued op", int'(busy), 0);
    compare_all("R12");
  endtask

  task automatic t_sector;  // R8
    send_cmd(2'd1, 12'h2A5);
    cs_end(1'b1, 1'b1);
    model_erase(12'h200, 1 << SECT_W);
    wait_op(T_ERASE, "R8");
    compare_all("R8");
  endtask

  task automatic t_block;  // R9
    do_prog(12'h7C0, 8, 8'h12, "R9");
    send_cmd(2'd2, 12'h7FF);
    cs_end(1'b1, 1'b1);
    model_erase(12'h400, 1 << BLK_W);
    wait_op(T_ERASE, "R9");
    compare_all("R9");
  endtask

  task automatic t_chip_prot;  // R10
    do_prog(12'h020, 6, 8'h90, "R10");
    do_prog(12'h520, 6, 8'h90, "R10");
    prot_lo_en = 1'b1;
    send_cmd(2'd3, 12'h555);
    cs_end(1'b1, 1'b1);
    model_erase(256, DEPTH - 256);
    wait_op(T_ERASE, "R10");
    prot_lo_en = 1'b0;
    compare_all("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_init();
    t_prog_basic();
    t_prog_wrap();
    t_prog_overflow();
    t_prog_and();
    t_misaligned();
    t_reject();
    t_busy_ignore();
    t_sector();
    t_block();
    t_chip_prot();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule